// File: doc/BRIEF.md
# Buffer RAM Window Address Translator

This block sits between an 8-bit-class microcontroller and the sector buffer RAM of an optical-disc data path. Every address the controller places on its 64 KB external data bus is classified into one of several regions and, where it lands in RAM, turned into a linear buffer address. The lowest 52 KB form a general scratchpad window, a 4 KB window above it can be pointed elsewhere on its own, and a 7.5 KB band splits into three 2.5 KB segments used for sector payload, subcode and header data. The top 256 bytes go to the device register file, and the 256 bytes just below that are unmapped.

The two windows are relocated in 1 KB steps by programmable bases. Each segment has a programmable block number, and its linear address is block × 2560 + offset, formed as a shift-and-add. Sums wrap modulo the RAM size. The bases are written through a small configuration port. Each translation is registered, so the result appears one clock after the address is presented.

Top module: `buf_win_xlat`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ram_sel` and `reg_sel` are 0 and `ram_addr` and `reg_idx` are 0. Reset sets every base to 0.
- R2: A valid address below 0xD000 gives `ram_sel`=1 and `ram_addr` = (window-A base × 1024 + address) mod 2^RAM_AW.
- R3: A valid address in 0xD000–0xDFFF gives `ram_sel`=1 and `ram_addr` = (window-B base × 1024 + (address − 0xD000)) mod 2^RAM_AW.
- R4: A valid address in 0xE000 + k×0xA00 … 0xE000 + k×0xA00 + 0x9FF, where k = 0, 1, 2, gives `ram_sel`=1 and `ram_addr` = (segment-k block × 2560 + offset) mod 2^RAM_AW. Segment k covers all 2560 bytes, including the last byte.
- R5: A valid address in 0xFF00–0xFFFF gives `reg_sel`=1, `ram_sel`=0, `ram_addr`=0 and `reg_idx` = address[7:0].
- R6: A valid address in 0xFE00–0xFEFF raises neither strobe, and `ram_addr` and `reg_idx` are 0.
- R7: Results appear on the clock edge after the one that samples `cpu_valid`=1. A cycle with `cpu_valid`=0 yields no strobe and zero outputs on the next cycle.
- R8: A write with `cfg_we`=1 sets a base selected by `cfg_sel`. The codes are: 0 = window A and 1 = window B, both taking `cfg_data`[13:0] in KB units; 2, 3 and 4 = segment 0, 1 and 2 block numbers, taking all 16 bits. Codes 5–7 change nothing. A lookup in the same cycle as a write uses the old base, and lookups from the next cycle on use the new one.
- R9: Linear addresses wrap modulo 2^RAM_AW (default 24 bits, 16 MB), including block × 2560 products that overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Controller address is valid this cycle |
| cpu_addr | input | 16 | Controller external data-space address |
| cfg_we | input | 1 | Base write enable |
| cfg_sel | input | 3 | Base selector (0 win A, 1 win B, 2–4 segments) |
| cfg_data | input | 16 | Base value |
| ram_addr | output | RAM_AW | Linear buffer RAM address |
| ram_sel | output | 1 | Translated access hits buffer RAM |
| reg_sel | output | 1 | Access hits the register area |
| reg_idx | output | 8 | Register index within the top 256 bytes |

## Verification
Every lookup, whether it hits a strobe, falls in the hole or is idle, has exactly one result. That result is due one clock edge after the cycle that presents it. The driver stamps each expected result with that edge number, and the monitor compares only at the falling edge after it. Base writes are modelled with the old base for the lookup issued in the same cycle and the new base afterwards, which checks the one-cycle visibility rule at the ports.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    localparam int CPU_AW    = 16;
    localparam int BLK_W     = 16;
    localparam int KB_SHIFT  = 10;
    localparam int SEG_N     = 3;
    localparam int SEG_BYTES = 2560;
    localparam int REG_W     = 8;

    localparam logic [CPU_AW-1:0] WB_LO   = 16'hD000;
    localparam int                SEG_LO  = 32'hE000;
    localparam logic [CPU_AW-1:0] SEG_LO16 = 16'hE000;
    localparam logic [CPU_AW-1:0] HOLE_LO = 16'hFE00;
    localparam logic [CPU_AW-1:0] REG_LO  = 16'hFF00;

    typedef enum logic [2:0] {
        RG_WA   = 3'd0,
        RG_WB   = 3'd1,
        RG_SEG  = 3'd2,
        RG_HOLE = 3'd3,
        RG_REG  = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        CS_WA   = 3'd0,
        CS_WB   = 3'd1,
        CS_SEG0 = 3'd2,
        CS_SEG1 = 3'd3,
        CS_SEG2 = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        region_e           rg;
        logic [1:0]        seg;
        logic [CPU_AW-1:0] off;
    } dec_t;

    // block * 2560 + off, with 2560 = 2048 + 512
    function automatic logic [31:0] blk_to_lin(logic [BLK_W-1:0] blk,
                                               logic [CPU_AW-1:0] off);
        logic [31:0] b;
        b = {16'd0, blk};
        return (b << 11) + (b << 9) + {16'd0, off};
    endfunction

endpackage

// File: rtl/bwt_region_decode.sv
module bwt_region_decode
    import bwt_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    output dec_t              dec
);

    logic [SEG_N-1:0]             seg_hit;
    logic [SEG_N-1:0][CPU_AW-1:0] seg_off;

    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        localparam logic [16:0] LO = 17'(SEG_LO + k * SEG_BYTES);
        localparam logic [16:0] HI = 17'(SEG_LO + (k + 1) * SEG_BYTES);
        logic [16:0] a17;
        logic [16:0] d17;
        assign a17        = {1'b0, addr};
        assign d17        = a17 - LO;
        assign seg_hit[k] = (a17 >= LO) && (a17 < HI);
        assign seg_off[k] = d17[CPU_AW-1:0];
    end

    always_comb begin
        dec = '{rg: RG_HOLE, seg: 2'd0, off: '0};
        if (addr < WB_LO) begin
            dec.rg  = RG_WA;
            dec.off = addr;
        end else if (addr < SEG_LO16) begin
            dec.rg  = RG_WB;
            dec.off = addr - WB_LO;
        end else if (addr >= REG_LO) begin
            dec.rg  = RG_REG;
            dec.off = {8'd0, addr[7:0]};
        end else begin
            for (int k = 0; k < SEG_N; k++) begin
                if (seg_hit[k]) begin
                    dec.rg  = RG_SEG;
                    dec.seg = 2'(k);
                    dec.off = seg_off[k];
                end
            end
        end
    end

endmodule

// File: rtl/bwt_base_regs.sv
module bwt_base_regs
    import bwt_pkg::*;
#(
    parameter int KB_W = 14
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [2:0]                  cfg_sel,
    input  logic [15:0]                 cfg_data,
    output logic [KB_W-1:0]             win_a_kb,
    output logic [KB_W-1:0]             win_b_kb,
    output logic [SEG_N-1:0][BLK_W-1:0] seg_blk
);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_a_kb <= '0;
            win_b_kb <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == CS_WA) win_a_kb <= cfg_data[KB_W-1:0];
            if (cfg_sel == CS_WB) win_b_kb <= cfg_data[KB_W-1:0];
        end
    end

    for (genvar k = 0; k < SEG_N; k++) begin : g_blk
        localparam logic [2:0] CODE = 3'(CS_SEG0 + k);
        always_ff @(posedge clk) begin
            if (rst)
                seg_blk[k] <= '0;
            else if (cfg_we && cfg_sel == CODE)
                seg_blk[k] <= cfg_data;
        end
    end

    // R8: bases move only on a write
    a_r8_win_a_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(win_a_kb));
    a_r8_win_b_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(win_b_kb));
    a_r8_seg_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(seg_blk));

endmodule

// File: rtl/bwt_lin_calc.sv
module bwt_lin_calc
    import bwt_pkg::*;
#(
    parameter int RAM_AW = 24,
    parameter int KB_W   = RAM_AW - KB_SHIFT
) (
    input  dec_t                        dec,
    input  logic [KB_W-1:0]             win_a_kb,
    input  logic [KB_W-1:0]             win_b_kb,
    input  logic [SEG_N-1:0][BLK_W-1:0] seg_blk,
    output logic [RAM_AW-1:0]           lin,
    output logic                        hit_ram,
    output logic                        hit_reg
);

    logic [31:0]      sum;
    logic [BLK_W-1:0] blk;

    always_comb begin
        case (dec.seg)
            2'd0:    blk = seg_blk[0];
            2'd1:    blk = seg_blk[1];
            default: blk = seg_blk[2];
        endcase
    end

    always_comb begin
        sum     = '0;
        hit_ram = 1'b0;
        hit_reg = 1'b0;
        unique case (dec.rg)
            RG_WA: begin
                sum     = 32'({win_a_kb, {KB_SHIFT{1'b0}}}) + {16'd0, dec.off};
                hit_ram = 1'b1;
            end
            RG_WB: begin
                sum     = 32'({win_b_kb, {KB_SHIFT{1'b0}}}) + {16'd0, dec.off};
                hit_ram = 1'b1;
            end
            RG_SEG: begin
                sum     = blk_to_lin(blk, dec.off);
                hit_ram = 1'b1;
            end
            RG_REG:  hit_reg = 1'b1;
            default: ;
        endcase
        lin = sum[RAM_AW-1:0];
    end

endmodule

// File: rtl/buf_win_xlat.sv
module buf_win_xlat
    import bwt_pkg::*;
#(
    parameter int RAM_AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [15:0]       cpu_addr,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [15:0]       cfg_data,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_sel,
    output logic              reg_sel,
    output logic [7:0]        reg_idx
);

    localparam int KB_W = RAM_AW - KB_SHIFT;

    dec_t                        dec;
    logic [KB_W-1:0]             win_a_kb;
    logic [KB_W-1:0]             win_b_kb;
    logic [SEG_N-1:0][BLK_W-1:0] seg_blk;
    logic [RAM_AW-1:0]           lin;
    logic                        hit_ram;
    logic                        hit_reg;

    bwt_region_decode u_dec (
        .addr (cpu_addr),
        .dec  (dec)
    );

    bwt_base_regs #(.KB_W(KB_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .win_a_kb (win_a_kb),
        .win_b_kb (win_b_kb),
        .seg_blk  (seg_blk)
    );

    bwt_lin_calc #(.RAM_AW(RAM_AW), .KB_W(KB_W)) u_calc (
        .dec      (dec),
        .win_a_kb (win_a_kb),
        .win_b_kb (win_b_kb),
        .seg_blk  (seg_blk),
        .lin      (lin),
        .hit_ram  (hit_ram),
        .hit_reg  (hit_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_addr <= '0;
            ram_sel  <= 1'b0;
            reg_sel  <= 1'b0;
            reg_idx  <= '0;
        end else begin
            ram_sel  <= cpu_valid && hit_ram;
            reg_sel  <= cpu_valid && hit_reg;
            ram_addr <= (cpu_valid && hit_ram) ? lin : '0;
            reg_idx  <= (cpu_valid && hit_reg) ? dec.off[REG_W-1:0] : '0;
        end
    end

    // R7: an idle cycle yields no strobe on the next
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(cpu_valid) |-> (!ram_sel && !reg_sel && ram_addr == '0));
    // R6: the unmapped page raises nothing
    a_r6_hole_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_valid) && $past(cpu_addr[15:8]) == 8'hFE) |-> (!ram_sel && !reg_sel));
    // R5: register page selects registers with the low byte as index
    a_r5_reg_page: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_valid) && $past(cpu_addr[15:8]) == 8'hFF)
            |-> (reg_sel && !ram_sel && reg_idx == $past(cpu_addr[7:0])));
    // R2: window A addresses always reach RAM
    a_r2_win_a_hit: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_valid) && $past(cpu_addr) < 16'hD000) |-> (ram_sel && !reg_sel));
    // R4: the segment band always reaches RAM
    a_r4_seg_hit: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_valid) && $past(cpu_addr) >= 16'hE000 && $past(cpu_addr) < 16'hFE00)
            |-> ram_sel);

endmodule

// File: tb/buf_win_xlat_tb.sv
`timescale 1ns/1ps
module buf_win_xlat_tb;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [15:0]   cfg_data = '0;
    logic [AW-1:0] ram_addr;
    logic          ram_sel;
    logic          reg_sel;
    logic [7:0]    reg_idx;

    always #2.5 clk = ~clk;

    buf_win_xlat #(.RAM_AW(AW)) u_dut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .ram_addr(ram_addr), .ram_sel(ram_sel), .reg_sel(reg_sel), .reg_idx(reg_idx)
    );

    typedef struct packed {
        logic          rs;
        logic          gs;
        logic [AW-1:0] a;
        logic [7:0]    idx;
    } exp_t;

    exp_t     eq[$];
    int       dq[$];
    string    tq[$];
    int       cyc = 0;
    int       n_chk = 0;
    int       n_bad = 0;
    bit       done = 0;
    longint   sh_a = 0, sh_b = 0;
    longint   sh_blk[3] = '{0, 0, 0};

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t model(bit v, logic [15:0] ad);
        exp_t   e;
        longint m;
        longint ai;
        e = '0;
        ai = longint'(ad);
        m = longint'(1) << AW;
        if (!v) return e;
        if (ai < 'hD000) begin
            e.rs = 1; e.a = AW'((sh_a * 1024 + ai) % m);
        end else if (ai < 'hE000) begin
            e.rs = 1; e.a = AW'((sh_b * 1024 + ai - 'hD000) % m);
        end else if (ai < 'hFE00) begin
            int k;
            k = int'((ai - 'hE000) / 2560);
            e.rs = 1; e.a = AW'((sh_blk[k] * 2560 + (ai - 'hE000 - k * 2560)) % m);
        end else if (ai >= 'hFF00) begin
            e.gs = 1; e.idx = ad[7:0];
        end
        return e;
    endfunction

    task automatic drive(bit v, logic [15:0] ad, bit we, logic [2:0] sel,
                         logic [15:0] d, string tag);
        @(negedge clk);
        cpu_valid = v; cpu_addr = ad;
        cfg_we = we; cfg_sel = sel; cfg_data = d;
        eq.push_back(model(v, ad));
        dq.push_back(cyc + 1);
        tq.push_back(tag);
        if (we) begin
            case (sel)
                3'd0: sh_a = longint'(d & 16'h3FFF);
                3'd1: sh_b = longint'(d & 16'h3FFF);
                3'd2: sh_blk[0] = longint'(d);
                3'd3: sh_blk[1] = longint'(d);
                3'd4: sh_blk[2] = longint'(d);
                default: ;
            endcase
        end
    endtask

    task automatic look(logic [15:0] ad, string tag);
        drive(1, ad, 0, 3'd0, 16'd0, tag);
    endtask

    task automatic cfg(logic [2:0] sel, logic [15:0] d, string tag);
        drive(0, 16'd0, 1, sel, d, tag);
    endtask

    always @(negedge clk) begin
        while (eq.size() > 0 && dq[0] <= cyc) begin
            exp_t  e;
            string t;
            e = eq.pop_front();
            void'(dq.pop_front());
            t = tq.pop_front();
            n_chk++;
            if (ram_sel !== e.rs || reg_sel !== e.gs || ram_addr !== e.a || reg_idx !== e.idx) begin
                n_bad++;
                $display("FAIL %s: got ram_sel=%0b reg_sel=%0b ram_addr=%h reg_idx=%h, expected %0b %0b %h %h",
                         t, ram_sel, reg_sel, ram_addr, reg_idx, e.rs, e.gs, e.a, e.idx);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle during reset
        n_chk++;
        if (ram_sel !== 0 || reg_sel !== 0 || ram_addr !== '0 || reg_idx !== '0) begin
            n_bad++;
            $display("FAIL R1: got %0b %0b %h %h, expected 0 0 0 0", ram_sel, reg_sel, ram_addr, reg_idx);
        end
        rst = 0;
        drive(0, 16'h0000, 0, 3'd0, 16'd0, "R1 first cycle");
        look(16'h0123, "R1 zero base window A");
        look(16'hE005, "R1 zero segment base");
        // window A
        cfg(3'd0, 16'd5, "R8 idle");
        look(16'h1000, "R2 base 5");
        look(16'hCFFF, "R2 top of window A");
        cfg(3'd0, 16'hFFFF, "R8 idle");
        look(16'hCFFF, "R9 window A wrap, upper base bits dropped");
        look(16'h0000, "R2 base max, offset 0");
        // window B
        cfg(3'd1, 16'd7, "R8 idle");
        look(16'hD000, "R3 bottom");
        look(16'hDFFF, "R3 top");
        look(16'h0400, "R8 window A unchanged by window B write");
        // segments
        cfg(3'd2, 16'd3, "R8 idle");
        cfg(3'd3, 16'h1234, "R8 idle");
        cfg(3'd4, 16'hFFFF, "R8 idle");
        look(16'hE000, "R4 seg0 first");
        look(16'hE9FF, "R4 seg0 last");
        look(16'hEA00, "R4 seg1 first");
        look(16'hF3FF, "R4 seg1 last");
        look(16'hF400, "R4 seg2 first");
        look(16'hFDFF, "R9 seg2 last with overflow");
        // registers and hole
        look(16'hFF00, "R5 first register");
        look(16'hFFA7, "R5 mid register");
        look(16'hFFFF, "R5 last register");
        look(16'hFE00, "R6 hole bottom");
        look(16'hFEFF, "R6 hole top");
        // idle cycle after a hit
        drive(0, 16'h0100, 0, 3'd0, 16'd0, "R7 idle after valid");
        look(16'h0100, "R7 back-to-back 1");
        look(16'hDF00, "R7 back-to-back 2");
        // same-cycle write and lookup
        drive(1, 16'h0010, 1, 3'd0, 16'd40, "R8 same-cycle uses old base");
        look(16'h0010, "R8 next cycle uses new base");
        drive(1, 16'hEA10, 1, 3'd3, 16'd9, "R8 same-cycle seg uses old block");
        look(16'hEA10, "R8 next cycle seg uses new block");
        // ignored selector codes
        drive(0, 16'd0, 1, 3'd5, 16'h0FFF, "R8 idle");
        drive(0, 16'd0, 1, 3'd7, 16'h0FFF, "R8 idle");
        look(16'h0010, "R8 code 5/7 leave window A");
        look(16'hE000, "R8 code 5/7 leave seg0");
        look(16'hD010, "R8 code 5/7 leave window B");
        drive(0, 16'd0, 0, 3'd0, 16'd0, "R7 final idle");
        repeat (3) @(negedge clk);
        if (eq.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R7: got %0d pending results, expected 0", eq.size());
        end
        finish_run();
    end

endmodule